// File: doc/BRIEF.md
# Burst Pattern Generator

This block drives the digital logic inputs of a high-voltage pulser. It plays a short, fixed pattern on a set of drive lines and controls an enable line. A front panel of five active-high pushbuttons sets it up. Each button passes through a synchroniser and a debouncer, and its action fires once, when it is released. One button starts and stops the output. Three buttons each step one setting: the waveform (A to E), the burst period, and how many times the pattern repeats in a burst. The fifth button restores the defaults.

While the block is running, a free-running burst timer triggers it. On each trigger it plays the selected waveform the selected number of times, one after another, and then holds the lines low until the next trigger. Waveform E is the exception. It plays continuously, with no gap between patterns, and it ignores the repeat setting. While E plays, the enable line is gated by a slow signal with a low duty cycle. A new setting never cuts a pattern short: the block picks it up only at the next trigger or at the next pattern boundary.

Timing is set in clock cycles. At the default values and a 200 MHz clock, the burst periods are 50 us, 100 us, 500 us and 1 ms, the debounce time is 10 ms, and the enable gate is high for 10 ms out of every 100 ms.

Top module: `burst_pattern_gen`

## Requirements
- R1: The run button toggles between stop and run. While stopped, en_o is low and drv_o is all zero, starting one clock after the stop takes effect.
- R2: Each button is synchronised and debounced. A level must hold for DEB_CYC cycles to count as a change, and the action fires once, on release. A pulse shorter than DEB_CYC cycles has no effect.
- R3: Releasing the waveform button steps the selection A, B, C, D, E and then back to A.
- R4: Waveform w (A=0 up to E=4) has four steps, and each step lasts (w+1)*STEP_CYC cycles. In steps s=0,1,2 only drv_o bit (w+s) mod NLINES is high. In step 3 all lines are low.
- R5: Releasing the rate button steps the burst period through UNIT_CYC times 1, 2, 10 and 20, then back to 1. For waveforms A to D, bursts start exactly one period apart.
- R6: Releasing the repeat button steps the repeat count through 1, 2, 4 and 8, then back to 1. A burst plays the pattern that many times in a row.
- R7: A new waveform is picked up only at a burst start or at the end of a pattern. A pattern that has started always completes.
- R8: Waveform E plays continuously with no gap between patterns, and the repeat count has no effect on it.
- R9: While E plays, en_o is high for CW_HIGH cycles out of every CW_PERIOD cycles.
- R10: While running with waveforms A to D, en_o stays high.
- R11: The home button selects waveform A, the shortest period and a repeat count of 1, and puts the block in run mode.
- R12: After rst_n, the block is stopped with waveform A, the shortest period and a repeat count of 1 selected, and both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_run_i | input | 1 | Run/stop button, high while pressed |
| btn_wave_i | input | 1 | Waveform-step button, high while pressed |
| btn_rate_i | input | 1 | Burst-period-step button, high while pressed |
| btn_rep_i | input | 1 | Repeat-count-step button, high while pressed |
| btn_home_i | input | 1 | Restore-defaults button, high while pressed |
| drv_o | output | NLINES | Pulser drive lines |
| en_o | output | 1 | Pulser enable |

## Verification
On every cycle, the assertions check the following:
- the drive lines are one-hot or zero;
- the output clears after a stop;
- the active waveform holds steady inside a pattern;
- a burst starts only on a timer tick or in continuous mode;
- continuous mode never drops out between patterns;
- a debouncer pulse follows a real settled release;
- the home and wrap updates of the panel are correct.

The exact step sequences, the spacing between burst starts, the number of repeats, the 75% line activity and the 10% enable duty in continuous mode, and the rejection of a short glitch can only be shown by the bench's directed scenarios. The same holds for a waveform change made mid-pattern that still lets the pattern complete.

// File: rtl/bpg_pkg.sv
`timescale 1ns/1ps
package bpg_pkg;
    localparam int NWAVE  = 5;
    localparam int NSTEP  = 4;
    localparam int WAVE_W = 3;

    typedef struct packed {
        logic              run;
        logic [WAVE_W-1:0] wave;
        logic [1:0]        rate;
        logic [1:0]        rep;
    } panel_t;

    function automatic int rate_mult(input logic [1:0] idx);
        case (idx)
            2'd0:    return 1;
            2'd1:    return 2;
            2'd2:    return 10;
            default: return 20;
        endcase
    endfunction

    function automatic logic [3:0] rep_count(input logic [1:0] idx);
        return 4'b0001 << idx;
    endfunction
endpackage

// File: rtl/bpg_debounce.sv
`timescale 1ns/1ps
module bpg_debounce #(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic rel_o
);
    localparam int CW = $clog2(DEB_CYC + 1);

    typedef struct packed {
        logic [1:0]    sync;
        logic          stable;
        logic [CW-1:0] cnt;
        logic          rel;
    } deb_t;

    deb_t deb_d, deb_q;

    always_comb begin
        deb_d      = deb_q;
        deb_d.sync = {deb_q.sync[0], raw_i};
        deb_d.rel  = 1'b0;
        if (deb_q.sync[1] == deb_q.stable) begin
            deb_d.cnt = '0;
        end else if (deb_q.cnt == CW'(DEB_CYC - 1)) begin
            deb_d.cnt    = '0;
            deb_d.stable = deb_q.sync[1];
            deb_d.rel    = deb_q.stable;
        end else begin
            deb_d.cnt = deb_q.cnt + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) deb_q <= '0;
        else        deb_q <= deb_d;
    end

    assign rel_o = deb_q.rel;

    // R2
    rel_settled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deb_q.rel |-> (!deb_q.stable && $past(deb_q.stable)));
    // R2
    rel_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        deb_q.rel |=> !deb_q.rel);
endmodule

// File: rtl/bpg_panel.sv
`timescale 1ns/1ps
module bpg_panel
    import bpg_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [4:0] rel_i,
    output panel_t     cfg_o
);
    panel_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (rel_i[4]) begin
            cfg_d.run  = 1'b1;
            cfg_d.wave = '0;
            cfg_d.rate = '0;
            cfg_d.rep  = '0;
        end else begin
            if (rel_i[0]) cfg_d.run = ~cfg_q.run;
            if (rel_i[1]) cfg_d.wave = (cfg_q.wave == WAVE_W'(NWAVE - 1)) ? '0 : cfg_q.wave + WAVE_W'(1);
            if (rel_i[2]) cfg_d.rate = cfg_q.rate + 2'd1;
            if (rel_i[3]) cfg_d.rep  = cfg_q.rep + 2'd1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg_o = cfg_q;

    // R11
    home_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rel_i[4] |=> (cfg_q.run && cfg_q.wave == '0 && cfg_q.rate == '0 && cfg_q.rep == '0));
    // R3
    wave_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_i[1] && !rel_i[4] && cfg_q.wave == WAVE_W'(NWAVE - 1)) |=> cfg_q.wave == '0);
endmodule

// File: rtl/bpg_player.sv
`timescale 1ns/1ps
module bpg_player
    import bpg_pkg::*;
#(
    parameter int NLINES    = 4,
    parameter int STEP_CYC  = 20,
    parameter int UNIT_CYC  = 10000,
    parameter int CW_PERIOD = 20000000,
    parameter int CW_HIGH   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  panel_t            cfg_i,
    output logic [NLINES-1:0] drv_o,
    output logic              en_o
);
    localparam int TW = $clog2(20 * UNIT_CYC + 1);
    localparam int GW = $clog2(CW_PERIOD + 1);
    localparam int DW = $clog2(NWAVE * STEP_CYC + 1);
    localparam logic [WAVE_W-1:0] WAVE_CW = WAVE_W'(NWAVE - 1);

    typedef struct packed {
        logic              busy;
        logic [WAVE_W-1:0] wave;
        logic [1:0]        step;
        logic [DW-1:0]     dcnt;
        logic [3:0]        left;
        logic [TW-1:0]     tcnt;
        logic [TW-1:0]     per;
        logic [GW-1:0]     gcnt;
    } play_t;

    play_t play_d, play_q;
    logic          tick, cw_sel, cw_act, last_step, start_new;
    logic [DW-1:0] dur;
    int            lane;

    always_comb begin
        play_d    = play_q;
        tick      = (play_q.tcnt == play_q.per - TW'(1));
        cw_sel    = (cfg_i.wave == WAVE_CW);
        cw_act    = play_q.busy ? (play_q.wave == WAVE_CW) : cw_sel;
        dur       = DW'((int'(play_q.wave) + 1) * STEP_CYC);
        last_step = (play_q.dcnt == dur - DW'(1)) && (play_q.step == 2'(NSTEP - 1));
        start_new = 1'b0;

        play_d.tcnt = tick ? '0 : play_q.tcnt + TW'(1);
        if (tick) play_d.per = TW'(rate_mult(cfg_i.rate) * UNIT_CYC);

        if (!cfg_i.run) begin
            play_d.busy = 1'b0;
            play_d.step = '0;
            play_d.dcnt = '0;
        end else if (play_q.busy) begin
            if (play_q.dcnt == dur - DW'(1)) begin
                play_d.dcnt = '0;
                if (play_q.step == 2'(NSTEP - 1)) begin
                    play_d.step = '0;
                    if (play_q.left == 4'd1) begin
                        if (cw_sel) start_new = 1'b1;
                        else        play_d.busy = 1'b0;
                    end else begin
                        play_d.left = play_q.left - 4'd1;
                    end
                end else begin
                    play_d.step = play_q.step + 2'd1;
                end
            end else begin
                play_d.dcnt = play_q.dcnt + DW'(1);
            end
        end else if (tick || cw_sel) begin
            start_new = 1'b1;
        end

        if (start_new) begin
            play_d.busy = 1'b1;
            play_d.wave = cfg_i.wave;
            play_d.step = '0;
            play_d.dcnt = '0;
            play_d.left = cw_sel ? 4'd1 : rep_count(cfg_i.rep);
        end

        if (cfg_i.run && cw_act)
            play_d.gcnt = (play_q.gcnt == GW'(CW_PERIOD - 1)) ? '0 : play_q.gcnt + GW'(1);
        else
            play_d.gcnt = '0;

        lane  = (int'(play_q.wave) + int'(play_q.step)) % NLINES;
        drv_o = (play_q.busy && play_q.step != 2'(NSTEP - 1)) ? (NLINES'(1) << lane) : '0;
        en_o  = cfg_i.run && (!cw_act || play_q.gcnt < GW'(CW_HIGH));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            play_q     <= '0;
            play_q.per <= TW'(UNIT_CYC);
        end else begin
            play_q <= play_d;
        end
    end

    // R4
    lines_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(drv_o));
    // R1
    stop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i.run |=> drv_o == '0);
    // R7
    wave_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_q.busy && cfg_i.run && !last_step) |=> $stable(play_q.wave));
    // R5
    start_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(play_q.busy) |-> ($past(tick) || $past(cw_sel)));
    // R8
    cw_nogap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (play_q.busy && cfg_i.run && cw_sel) |=> play_q.busy);
    // R9
    gate_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        play_q.gcnt < GW'(CW_PERIOD));
endmodule

// File: rtl/burst_pattern_gen.sv
`timescale 1ns/1ps
module burst_pattern_gen
    import bpg_pkg::*;
#(
    parameter int NLINES    = 4,
    parameter int STEP_CYC  = 20,
    parameter int UNIT_CYC  = 10000,
    parameter int DEB_CYC   = 2000000,
    parameter int CW_PERIOD = 20000000,
    parameter int CW_HIGH   = 2000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              btn_run_i,
    input  logic              btn_wave_i,
    input  logic              btn_rate_i,
    input  logic              btn_rep_i,
    input  logic              btn_home_i,
    output logic [NLINES-1:0] drv_o,
    output logic              en_o
);
    localparam int NBTN = 5;

    logic [NBTN-1:0] btn_raw, btn_rel;
    panel_t          cfg;

    assign btn_raw = {btn_home_i, btn_rep_i, btn_rate_i, btn_wave_i, btn_run_i};

    for (genvar g = 0; g < NBTN; g++) begin : g_deb
        bpg_debounce #(.DEB_CYC(DEB_CYC)) i_deb (
            .clk   (clk),
            .rst_n (rst_n),
            .raw_i (btn_raw[g]),
            .rel_o (btn_rel[g])
        );
    end

    bpg_panel i_panel (
        .clk   (clk),
        .rst_n (rst_n),
        .rel_i (btn_rel),
        .cfg_o (cfg)
    );

    bpg_player #(
        .NLINES    (NLINES),
        .STEP_CYC  (STEP_CYC),
        .UNIT_CYC  (UNIT_CYC),
        .CW_PERIOD (CW_PERIOD),
        .CW_HIGH   (CW_HIGH)
    ) i_player (
        .clk   (clk),
        .rst_n (rst_n),
        .cfg_i (cfg),
        .drv_o (drv_o),
        .en_o  (en_o)
    );
endmodule

// File: tb/test_burst_pattern_gen.sv
`timescale 1ns/1ps
module test_burst_pattern_gen;
    localparam int NL = 4, STEP = 1, UNIT = 200, DEB = 4, CWP = 100, CWH = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] btn = '0;
    logic [NL-1:0] drv;
    logic       en;

    int nchk = 0, nfail = 0;
    int cyc = 0, zrun = 100, start_cnt = 0, last_start = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    burst_pattern_gen #(
        .NLINES(NL), .STEP_CYC(STEP), .UNIT_CYC(UNIT), .DEB_CYC(DEB),
        .CW_PERIOD(CWP), .CW_HIGH(CWH)
    ) i_burst_pattern_gen (
        .clk(clk), .rst_n(rst_n),
        .btn_run_i(btn[0]), .btn_wave_i(btn[1]), .btn_rate_i(btn[2]),
        .btn_rep_i(btn[3]), .btn_home_i(btn[4]),
        .drv_o(drv), .en_o(en)
    );

    always @(negedge clk) begin
        cyc++;
        if (drv != '0) begin
            if (zrun >= 8) begin
                last_start = cyc;
                start_cnt++;
            end
            zrun = 0;
        end else begin
            zrun++;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic press(input int b);
        btn[b] = 1'b1;
        repeat (10) @(negedge clk);
        btn[b] = 1'b0;
        repeat (12) @(negedge clk);
    endtask

    task automatic wait_start();
        int s = start_cnt;
        wait (start_cnt != s);
    endtask

    function automatic int exp_line(input int w, input int i);
        int s = i / ((w + 1) * STEP);
        return (s < 3) ? (1 << ((w + s) % NL)) : 0;
    endfunction

    task automatic seq_from_now(input string req, input int w);
        int bad = 0, first_act = 0, first_exp = 0;
        for (int i = 0; i < 4 * (w + 1) * STEP; i++) begin
            if (i > 0) @(negedge clk);
            if (int'(drv) != exp_line(w, i) && bad == 0) begin
                bad = 1; first_act = int'(drv); first_exp = exp_line(w, i);
            end
        end
        chk(req, first_act, first_exp);
    endtask

    task automatic check_seq(input string req, input int w);
        wait_start();
        seq_from_now(req, w);
    endtask

    task automatic burst_hits(input string req, input int exp);
        int hits;
        wait_start();
        hits = (drv == NL'(1)) ? 1 : 0;
        repeat (150) begin
            @(negedge clk);
            if (drv == NL'(1)) hits++;
        end
        chk(req, hits, exp);
    endtask

    task automatic period(input string req, input int exp);
        int t0;
        wait_start();
        wait_start();
        t0 = last_start;
        wait_start();
        chk(req, last_start - t0, exp);
    endtask

    task automatic window(input int n, output int act_cnt, output int en_cnt);
        act_cnt = 0; en_cnt = 0;
        repeat (n) begin
            @(negedge clk);
            if (drv != '0) act_cnt++;
            if (en) en_cnt++;
        end
    endtask

    task automatic t_reset();
        int a, e;
        chk("R12 drv at reset", int'(drv), 0);
        chk("R12 en at reset", int'(en), 0);
        window(300, a, e);
        chk("R1 no lines while stopped", a, 0);
        chk("R1 no enable while stopped", e, 0);
    endtask

    task automatic t_run_a();
        press(0);
        chk("R10 en high when running A", int'(en), 1);
        check_seq("R4 R12 waveform A", 0);
        period("R5 R12 default period", UNIT);
        burst_hits("R6 R12 default repeat", 1);
        btn[1] = 1'b1;
        repeat (2) @(negedge clk);
        btn[1] = 1'b0;
        repeat (20) @(negedge clk);
        wait_start();
        check_seq("R2 glitch ignored", 0);
    endtask

    task automatic t_rep();
        int exp_tab[4] = '{2, 4, 8, 1};
        foreach (exp_tab[k]) begin
            press(3);
            wait_start();
            burst_hits("R6 repeat step/wrap", exp_tab[k]);
        end
    endtask

    task automatic t_rate();
        int exp_tab[4] = '{2 * UNIT, 10 * UNIT, 20 * UNIT, UNIT};
        foreach (exp_tab[k]) begin
            press(2);
            period("R5 period step/wrap", exp_tab[k]);
        end
    endtask

    task automatic t_waves();
        press(1); wait_start(); check_seq("R3 R4 waveform B", 1);
        press(1); wait_start(); check_seq("R3 R4 waveform C", 2);
        press(1); wait_start(); check_seq("R3 R4 waveform D", 3);
    endtask

    task automatic t_hold();
        btn[1] = 1'b1;
        repeat (10) @(negedge clk);
        wait_start();
        btn[1] = 1'b0;
        seq_from_now("R7 pattern completes after mid-pattern change", 3);
    endtask

    task automatic t_cw();
        int a, e;
        repeat (60) @(negedge clk);
        press(3); press(3); press(3);
        window(CWP, a, e);
        chk("R8 continuous activity with repeat 8", a, 75);
        chk("R9 enable duty in E", e, CWH);
    endtask

    task automatic t_wrap();
        int a, e;
        press(1);
        wait_start();
        seq_from_now("R3 wrap E to A", 0);
        window(CWP, a, e);
        chk("R10 en steady after leaving E", e, CWP);
    endtask

    task automatic t_home();
        press(2);
        press(0);
        press(4);
        chk("R11 en after home", int'(en), 1);
        check_seq("R11 waveform A after home", 0);
        period("R11 period after home", UNIT);
        burst_hits("R11 repeat after home", 1);
    endtask

    task automatic t_stop();
        int a, e;
        press(0);
        window(300, a, e);
        chk("R1 lines after stop", a, 0);
        chk("R1 enable after stop", e, 0);
    endtask

    initial begin
        #(5.0 * 190000);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_run_a();
        t_rep();
        t_rate();
        t_waves();
        t_hold();
        t_cw();
        t_wrap();
        t_home();
        t_stop();
        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end
endmodule